// File: doc/BRIEF.md
# Hash Engine Command Error Checker

This block sits between the register interface of a keyed-hash accelerator and its datapath and decides which software actions are legal. It observes register writes (configuration, command, interrupt control and secret-key words), pushes toward the message FIFO and a completion pulse from the hash core. From these it tracks whether the engine is idle or active. Legal key writes and message pushes are passed on to the datapath in the same cycle. Illegal ones are dropped.

Every rejected action stores a numeric code in an error register and sets a sticky error interrupt bit. The interrupt output is the AND of that bit and an enable bit. Software clears the bit by writing 1 to it, and a test register sets it without a real fault. The datapath, the FIFO storage and the bus fabric are outside this block.

Top module: `hash_cmd_guard`

## Requirements
- R1: After reset (asynchronous, active low) the error code is 0 (no error), the engine is idle, the interrupt state and enable are 0, `intr_o` is low and the configuration reads 0.
- R2: A start command (write to offset 0x14 with bit 0 set) while the hash-enable bit (configuration bit 1) is clear stores code 0x02, and the engine stays idle.
- R3: A write to a key word (offsets 0x24 up to 0x24+4*KEY_WORDS-4, word aligned) while the engine is active stores code 0x03 and does not raise `key_we_o`. The same write while idle raises `key_we_o` in that cycle and stores no code.
- R4: A start command while the engine is active stores code 0x04.
- R5: A push on `push_i` is forwarded on `fifo_push_o` in the same cycle only when hashing is enabled, the engine is active and no stop is pending. Otherwise it is dropped and code 0x05 is stored.
- R6: A start command with configuration bit 0 (HMAC enable) set and key-length field bits [10:8] equal to 0, or with digest field bits [5:4] equal to 0, stores code 0x06, and the engine stays idle.
- R7: Start errors are ranked 0x02 before 0x04 before 0x06. When a register-write error and a push error occur in the same cycle, the register-write code is stored.
- R8: A legal start makes the engine active at the next edge, and `done_i` returns it to idle. A stop command (bit 2 at 0x14) blocks pushes, and a continue command (bit 3) allows them again. In one command write, start outranks stop, and stop outranks continue.
- R9: Writes to the configuration register (offset 0x10) are ignored while the engine is active.
- R10: Every stored error sets the error interrupt state (bit 2). `intr_o` is high exactly when that state and the enable (offset 0x04, bit 2) are both set.
- R11: Writing 1 to bit 2 at offset 0x00 clears the state. Writing 1 to bit 2 at offset 0x08 sets it. An error in the same cycle as a clear leaves the state set. The error register always holds the most recent code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the write |
| reg_wdata_i | input | DATA_W | Write data |
| push_i | input | 1 | Message word offered to the FIFO |
| push_data_i | input | DATA_W | Offered message word |
| done_i | input | 1 | Completion pulse from the hash core |
| fifo_push_o | output | 1 | Legal push forwarded to the FIFO |
| fifo_data_o | output | DATA_W | Forwarded message word |
| key_we_o | output | 1 | Legal key-word write |
| key_idx_o | output | KIDX_W | Index of the written key word |
| active_o | output | 1 | Engine active |
| cfg_o | output | 16 | Configuration in its register layout |
| err_code_o | output | 8 | Most recent error code |
| intr_state_o | output | 1 | Sticky error interrupt state |
| intr_enable_o | output | 1 | Error interrupt enable |
| intr_o | output | 1 | Error interrupt |

## Verification
The hardest conditions to reach are the collisions: a key write and an illegal push in the same cycle, and a clear write that meets a fresh error. The stimulus table first drives the engine active with a legal start and then issues a stop, which puts it in the state where pushes are refused. Only then does it send a key write and a push together. The rank between the 0x02 and 0x06 start errors is reached with a configuration that breaks both rules at once. The 0x04 and 0x06 pair is not tested, because the configuration cannot change while the engine is active.

// File: rtl/hcg_pkg.sv
package hcg_pkg;

  localparam int ERR_W = 8;

  // register byte offsets
  localparam int OFF_INTR_STATE = 'h00;
  localparam int OFF_INTR_EN    = 'h04;
  localparam int OFF_INTR_TEST  = 'h08;
  localparam int OFF_CFG        = 'h10;
  localparam int OFF_CMD        = 'h14;

  // bit positions
  localparam int BIT_IRQ_ERR = 2;
  localparam int BIT_START   = 0;
  localparam int BIT_STOP    = 2;
  localparam int BIT_CONT    = 3;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE       = 8'h00,
    ERR_START_OFF  = 8'h02,
    ERR_KEY_BUSY   = 8'h03,
    ERR_START_BUSY = 8'h04,
    ERR_PUSH       = 8'h05,
    ERR_BAD_CFG    = 8'h06
  } err_code_e;

  typedef struct packed {
    logic [2:0] key_len;  // bits [10:8], 0 = none
    logic [1:0] digest;   // bits [5:4],  0 = none
    logic       sha_en;   // bit 1
    logic       hmac_en;  // bit 0
  } cfg_t;

endpackage

// File: rtl/hcg_cfg_reg.sv
module hcg_cfg_reg
  import hcg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              active_i,
  output cfg_t              cfg_o
);

  cfg_t cfg_q, cfg_d;
  logic cfg_en;

  assign cfg_en = wr_i && !active_i;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) begin
      cfg_d.hmac_en = wdata_i[0];
      cfg_d.sha_en  = wdata_i[1];
      cfg_d.digest  = wdata_i[5:4];
      cfg_d.key_len = wdata_i[10:8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:11], wdata_i[7:6], wdata_i[3:2]};

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && active_i) |=> $stable(cfg_q));

endmodule

// File: rtl/hcg_rules.sv
module hcg_rules
  import hcg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 8,
  parameter int KEY_BASE  = 'h24,
  localparam int KIDX_W   = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              push_i,
  input  cfg_t              cfg_i,
  input  logic              active_i,
  input  logic              closing_i,
  output logic              start_go_o,
  output logic              stop_go_o,
  output logic              cont_go_o,
  output logic              cfg_wr_o,
  output logic              key_go_o,
  output logic [KIDX_W-1:0] key_idx_o,
  output logic              push_go_o,
  output logic              irq_clr_o,
  output logic              irq_test_o,
  output logic              irq_en_we_o,
  output logic              err_set_o,
  output err_code_e         err_code_o
);

  localparam logic [ADDR_W-1:0] KEY_LO = ADDR_W'(KEY_BASE);

  logic              cmd_wr, start_req, stop_req, cont_req;
  logic              key_hit, key_req;
  logic [ADDR_W-1:0] key_off;
  logic              bad_cfg, reg_err, push_err;
  err_code_e         reg_code;

  assign cmd_wr    = we_i && (addr_i == ADDR_W'(OFF_CMD));
  assign start_req = cmd_wr && wdata_i[BIT_START];
  assign stop_req  = cmd_wr && !wdata_i[BIT_START] && wdata_i[BIT_STOP];
  assign cont_req  = cmd_wr && !wdata_i[BIT_START] && !wdata_i[BIT_STOP]
                     && wdata_i[BIT_CONT];

  assign key_off = addr_i - KEY_LO;
  assign key_hit = (addr_i >= KEY_LO) && (key_off[1:0] == 2'b00)
                   && ({2'b00, key_off[ADDR_W-1:2]} < ADDR_W'(KEY_WORDS));
  assign key_req   = we_i && key_hit;
  assign key_idx_o = key_off[KIDX_W+1:2];

  assign cfg_wr_o    = we_i && (addr_i == ADDR_W'(OFF_CFG));
  assign irq_clr_o   = we_i && (addr_i == ADDR_W'(OFF_INTR_STATE)) && wdata_i[BIT_IRQ_ERR];
  assign irq_test_o  = we_i && (addr_i == ADDR_W'(OFF_INTR_TEST)) && wdata_i[BIT_IRQ_ERR];
  assign irq_en_we_o = we_i && (addr_i == ADDR_W'(OFF_INTR_EN));

  assign bad_cfg = (cfg_i.hmac_en && (cfg_i.key_len == 3'd0)) || (cfg_i.digest == 2'd0);

  always_comb begin
    reg_err  = 1'b0;
    reg_code = ERR_NONE;
    if (start_req) begin
      if (!cfg_i.sha_en) begin
        reg_err = 1'b1; reg_code = ERR_START_OFF;
      end else if (active_i) begin
        reg_err = 1'b1; reg_code = ERR_START_BUSY;
      end else if (bad_cfg) begin
        reg_err = 1'b1; reg_code = ERR_BAD_CFG;
      end
    end else if (key_req && active_i) begin
      reg_err = 1'b1; reg_code = ERR_KEY_BUSY;
    end
  end

  assign start_go_o = start_req && !reg_err;
  assign stop_go_o  = stop_req && active_i;
  assign cont_go_o  = cont_req && active_i;
  assign key_go_o   = key_req && !active_i;

  assign push_go_o = push_i && cfg_i.sha_en && active_i && !closing_i;
  assign push_err  = push_i && !push_go_o;

  assign err_set_o  = reg_err || push_err;
  assign err_code_o = reg_err ? reg_code : (push_err ? ERR_PUSH : ERR_NONE);

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:4], wdata_i[1]};

endmodule

// File: rtl/hcg_engine.sv
module hcg_engine (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_go_i,
  input  logic stop_go_i,
  input  logic cont_go_i,
  input  logic done_i,
  output logic active_o,
  output logic closing_o
);

  logic active_q, active_d, closing_q, closing_d;

  always_comb begin
    active_d  = active_q;
    closing_d = closing_q;
    if (start_go_i) begin
      active_d  = 1'b1;
      closing_d = 1'b0;
    end else if (done_i) begin
      active_d  = 1'b0;
      closing_d = 1'b0;
    end else if (stop_go_i) begin
      closing_d = 1'b1;
    end else if (cont_go_i) begin
      closing_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      closing_q <= 1'b0;
    end else begin
      active_q  <= active_d;
      closing_q <= closing_d;
    end
  end

  assign active_o  = active_q;
  assign closing_o = closing_q;

  // R8
  start_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_go_i |=> active_q);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_go_i) |=> !active_q);

  // R8
  closing_in_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    closing_q |-> active_q);

endmodule

// File: rtl/hcg_irq.sv
module hcg_irq
  import hcg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      err_set_i,
  input  err_code_e err_code_i,
  input  logic      clr_i,
  input  logic      test_i,
  input  logic      en_we_i,
  input  logic      en_wdata_i,
  output logic [ERR_W-1:0] code_o,
  output logic      state_o,
  output logic      en_o,
  output logic      intr_o
);

  logic [ERR_W-1:0] code_q, code_d;
  logic state_q, state_d, en_q, en_d;

  always_comb begin
    state_d = (state_q && !clr_i) || err_set_i || test_i;
    code_d  = err_set_i ? err_code_i : code_q;
    en_d    = en_we_i ? en_wdata_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      state_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (err_set_i) code_q <= code_d;
      if (en_we_i)   en_q   <= en_d;
    end
  end

  assign code_o  = code_q;
  assign state_o = state_q;
  assign en_o    = en_q;
  assign intr_o  = state_q && en_q;

  // R10
  err_sets_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i |=> state_q);

  // R11
  code_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i |=> (code_q == $past(err_code_i)));

  // R11
  clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !err_set_i && !test_i) |=> !state_q);

endmodule

// File: rtl/hash_cmd_guard.sv
module hash_cmd_guard
  import hcg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 8,
  parameter int KEY_BASE  = 'h24,
  localparam int KIDX_W   = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              done_i,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              key_we_o,
  output logic [KIDX_W-1:0] key_idx_o,
  output logic              active_o,
  output logic [15:0]       cfg_o,
  output logic [ERR_W-1:0]  err_code_o,
  output logic              intr_state_o,
  output logic              intr_enable_o,
  output logic              intr_o
);

  cfg_t      cfg;
  logic      active, closing;
  logic      start_go, stop_go, cont_go, cfg_wr, push_go;
  logic      irq_clr, irq_test, irq_en_we, err_set;
  err_code_e err_code;

  hcg_rules #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_WORDS(KEY_WORDS), .KEY_BASE(KEY_BASE)
  ) rules_i (
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .push_i(push_i), .cfg_i(cfg), .active_i(active), .closing_i(closing),
    .start_go_o(start_go), .stop_go_o(stop_go), .cont_go_o(cont_go),
    .cfg_wr_o(cfg_wr), .key_go_o(key_we_o), .key_idx_o(key_idx_o),
    .push_go_o(push_go), .irq_clr_o(irq_clr), .irq_test_o(irq_test),
    .irq_en_we_o(irq_en_we), .err_set_o(err_set), .err_code_o(err_code)
  );

  hcg_cfg_reg #(.DATA_W(DATA_W)) cfg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cfg_wr), .wdata_i(reg_wdata_i),
    .active_i(active), .cfg_o(cfg)
  );

  hcg_engine eng_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_go_i(start_go), .stop_go_i(stop_go),
    .cont_go_i(cont_go), .done_i(done_i), .active_o(active), .closing_o(closing)
  );

  hcg_irq irq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_set_i(err_set), .err_code_i(err_code),
    .clr_i(irq_clr), .test_i(irq_test), .en_we_i(irq_en_we),
    .en_wdata_i(reg_wdata_i[BIT_IRQ_ERR]), .code_o(err_code_o),
    .state_o(intr_state_o), .en_o(intr_enable_o), .intr_o(intr_o)
  );

  assign fifo_push_o = push_go;
  assign fifo_data_o = push_data_i;
  assign active_o    = active;
  assign cfg_o       = {5'b0, cfg.key_len, 2'b0, cfg.digest, 2'b0, cfg.sha_en, cfg.hmac_en};

  // R3
  key_idle_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_we_o |-> !active_o);

  // R5
  push_act_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> (active_o && cfg_o[1]));

  // R2
  rejected_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(OFF_CMD) && reg_wdata_i[BIT_START]
     && !active_o && !cfg_o[1]) |=> !active_o);

endmodule

// File: tb/hash_cmd_guard_tb.sv
module hash_cmd_guard_tb_top;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic        push;
    logic        done;
    logic        x_fwd;
    logic        x_key;
    logic [7:0]  x_code;
    logic        x_act;
    logic        x_irq;
    logic [15:0] x_cfg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 45;
  // we addr wd push done | fwd key | code act irq cfg | req
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h04, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000, 4'd10}, // R10 enable
    '{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1, 16'h0000, 4'd2},  // R2
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 16'h0000, 4'd11}, // R11 clear
    '{1'b1, 8'h10, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 16'h0001, 4'd9},
    '{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1, 16'h0001, 4'd7},  // R7 02 over 06
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 16'h0001, 4'd11},
    '{1'b1, 8'h10, 16'h0103, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 16'h0103, 4'd9},
    '{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0, 1'b1, 16'h0103, 4'd6},  // R6 digest none
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0, 1'b0, 16'h0103, 4'd11},
    '{1'b1, 8'h10, 16'h0013, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0, 1'b0, 16'h0013, 4'd9},
    '{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0, 1'b1, 16'h0013, 4'd6},  // R6 key none
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0, 1'b0, 16'h0013, 4'd11},
    '{1'b1, 8'h10, 16'h0113, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0, 1'b0, 16'h0113, 4'd9},
    '{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 1'b1, 1'b0, 16'h0113, 4'd8},  // R8 legal start
    '{1'b0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h06, 1'b1, 1'b0, 16'h0113, 4'd5},  // R5 legal push
    '{1'b1, 8'h24, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, 1'b1, 16'h0113, 4'd3},  // R3 key busy
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, 1'b0, 16'h0113, 4'd11},
    '{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b1, 1'b1, 16'h0113, 4'd4},  // R4
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b1, 1'b0, 16'h0113, 4'd11},
    '{1'b1, 8'h10, 16'h0012, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b1, 1'b0, 16'h0113, 4'd9},  // R9 ignored
    '{1'b1, 8'h14, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b1, 1'b0, 16'h0113, 4'd8},  // R8 stop
    '{1'b0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h05, 1'b1, 1'b1, 16'h0113, 4'd5},  // R5 after stop
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1'b1, 1'b0, 16'h0113, 4'd11},
    '{1'b1, 8'h28, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, 1'b1, 16'h0113, 4'd7},  // R7 reg over push
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, 1'b0, 16'h0113, 4'd11},
    '{1'b1, 8'h14, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, 1'b0, 16'h0113, 4'd8},  // R8 continue
    '{1'b0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h03, 1'b1, 1'b0, 16'h0113, 4'd8},
    '{1'b0, 8'h00, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 16'h0113, 4'd8},  // R8 done
    '{1'b1, 8'h00, 16'h0004, 1'b1, 1'b0, 1'b0, 1'b0, 8'h05, 1'b0, 1'b1, 16'h0113, 4'd11}, // R11 set wins
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 16'h0113, 4'd11},
    '{1'b1, 8'h2C, 16'h00AA, 1'b0, 1'b0, 1'b0, 1'b1, 8'h05, 1'b0, 1'b0, 16'h0113, 4'd3},  // R3 idle key
    '{1'b1, 8'h10, 16'h0012, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 16'h0012, 4'd9},
    '{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1'b1, 1'b0, 16'h0012, 4'd6},  // R6 hmac off ok
    '{1'b0, 8'h00, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 16'h0012, 4'd8},
    '{1'b1, 8'h10, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 16'h0010, 4'd9},
    '{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1, 16'h0010, 4'd2},
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 16'h0010, 4'd11},
    '{1'b0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h05, 1'b0, 1'b1, 16'h0010, 4'd5},  // R5 sha off
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 16'h0010, 4'd11},
    '{1'b1, 8'h08, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1'b0, 1'b1, 16'h0010, 4'd11}, // R11 test
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 16'h0010, 4'd11},
    '{1'b1, 8'h04, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 16'h0010, 4'd10},
    '{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 16'h0010, 4'd10}, // R10 masked
    '{1'b1, 8'h04, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1, 16'h0010, 4'd10},
    '{1'b1, 8'h00, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 16'h0010, 4'd11}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        push;
  logic [31:0] push_data;
  logic        done;
  logic        fifo_push;
  logic [31:0] fifo_data;
  logic        key_we;
  logic [2:0]  key_idx;
  logic        active;
  logic [15:0] cfg;
  logic [7:0]  err_code;
  logic        intr_state, intr_enable, intr;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hash_cmd_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .push_i(push), .push_data_i(push_data),
    .done_i(done), .fifo_push_o(fifo_push), .fifo_data_o(fifo_data),
    .key_we_o(key_we), .key_idx_o(key_idx), .active_o(active), .cfg_o(cfg),
    .err_code_o(err_code), .intr_state_o(intr_state),
    .intr_enable_o(intr_enable), .intr_o(intr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    push = 1'b0; push_data = '0; done = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    reg_we = v.we; reg_addr = v.addr; reg_wdata = {16'h0, v.wd};
    push = v.push; push_data = 32'hC0DE_0000 | 32'(v.wd); done = v.done;
    #1;
    check(fifo_push == v.x_fwd, tag, "fifo_push", 32'(fifo_push), 32'(v.x_fwd));
    check(key_we == v.x_key, tag, "key_we", 32'(key_we), 32'(v.x_key));
    @(posedge clk);
    @(negedge clk);
    check(err_code == v.x_code, tag, "err_code", 32'(err_code), 32'(v.x_code));
    check(active == v.x_act, tag, "active", 32'(active), 32'(v.x_act));
    check(intr == v.x_irq, tag, "intr", 32'(intr), 32'(v.x_irq));
    check(cfg == v.x_cfg, tag, "cfg", 32'(cfg), 32'(v.x_cfg));
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(err_code == 8'h00 && !active && !intr && !intr_state && !intr_enable
          && cfg == 16'h0, "R1", "reset", {err_code, 3'b0, active, intr,
          intr_state, intr_enable, cfg[8:0]}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R3 key index of a forwarded write at offset 0x30
    reg_we = 1'b1; reg_addr = 8'h30; reg_wdata = 32'h1;
    #1;
    check(key_we && key_idx == 3'd3, "R3", "key_idx", 32'(key_idx), 32'd3);
    @(negedge clk);
    idle_inputs();

    // R1 asynchronous reset while active with a stored error
    apply('{1'b1, 8'h10, 16'h0012, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 16'h0012, 4'd9});
    apply('{1'b1, 8'h14, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b1, 1'b0, 16'h0012, 4'd8});
    #2 rst_n = 1'b0;
    #1;
    check(err_code == 8'h00 && !active && !intr_state && !intr_enable && cfg == 16'h0,
          "R1", "async reset", {err_code, 7'b0, active, cfg}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule